// File: doc/BRIEF.md
# Banked Interrupt Priority Mask Register

This block is the priority mask register of an interrupt controller CPU interface. One 8-bit physical mask is shared by secure and non-secure software. The mask decides whether an incoming pending interrupt may be signalled to the processor: a priority value that is numerically lower than the mask passes, and anything else is held back. A mask of 0xFF lets every priority except 0xFF through.

Three conditions can hold together: the top security level is implemented, the access is non-secure, and the control bit that routes fast interrupts to the top level is set. When all three hold, non-secure software sees a translated view of the mask.
- On a read, the stored value is shifted left by one. If the stored value lies in the secure half of the range (bit 7 clear), the read returns zero instead.
- On a write, the value is shifted right by one and bit 7 is forced high. If the stored value lies in the secure half, the write is dropped.

Every other access reads and writes the raw value. Reads are combinational on the read strobe. Writes land on the next rising clock edge.

Top module: `prio_mask_bank`

## Requirements
- R1: After synchronous reset the stored mask is 0x00, so a raw read returns 0x00 and no pending interrupt is signalled.
- R2: When the translation condition does not hold (the access is secure, or the routing bit is clear), a read returns the stored mask unchanged and a write stores the written byte unchanged.
- R3: On a translated read with stored bit 7 = 1, `rd_data` is the stored value shifted left by one and truncated to 8 bits (0xFF reads as 0xFE).
- R4: On a translated read with stored bit 7 = 0, `rd_data` is 0x00 (0x7F reads as 0x00).
- R5: A translated write while stored bit 7 = 0 leaves the stored mask unchanged.
- R6: An accepted translated write stores {1'b1, wr_data[7:1]}.
- R7: `irq_ok` is 1 exactly when `pend_valid` is 1 and `pend_prio` is numerically lower than the stored mask; an equal value is masked.
- R8: `rd_data` reflects the stored mask in the same cycle as `rd_en` and is 0x00 when `rd_en` is 0. A write takes effect at the next rising edge, so a read in the write's cycle returns the old value.
- R9: With parameter HAS_TOP_EL = 0, no access is ever translated: non-secure reads and writes with the routing bit set behave as raw accesses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_ns | input | 1 | 1 = the current access is non-secure |
| route_top | input | 1 | Routing control: fast interrupts taken at the top level |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | PRIO_W | Write data |
| rd_data | output | PRIO_W | Read data for the requesting security state |
| pend_valid | input | 1 | A pending interrupt is presented |
| pend_prio | input | PRIO_W | Priority of the pending interrupt |
| irq_ok | output | 1 | The pending interrupt may be signalled |

## Verification
The bench builds two instances with PRIO_W = 8 from the same stimulus:
- **Default instance (HAS_TOP_EL = 1).** Every translation path is within reach: secure-range lockout, the shifted views, and the forced top bit.
- **Second instance (HAS_TOP_EL = 0).** It shows that the same non-secure, routed accesses stay raw.

The 8-bit width puts the 0x7F/0x80 boundary and the 0xFF corner within reach for directed checks. Random priorities drawn near the current mask exercise the equal-value masking.

// File: rtl/pmask_pkg.sv
package pmask_pkg;
  typedef enum logic [1:0] {
    ACC_RAW       = 2'd0,
    ACC_NS_OPEN   = 2'd1,
    ACC_NS_LOCKED = 2'd2
  } acc_kind_e;

  function automatic acc_kind_e classify(input logic has_el, input logic ns,
                                         input logic route, input logic top_bit);
    if (!(has_el && ns && route)) return ACC_RAW;
    else if (top_bit) return ACC_NS_OPEN;
    else return ACC_NS_LOCKED;
  endfunction
endpackage

// File: rtl/pmask_store.sv
module pmask_store
  import pmask_pkg::*;
#(
  parameter int PRIO_W = 8,
  parameter logic [PRIO_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  acc_kind_e         kind,
  input  logic [PRIO_W-1:0] wr_data,
  output logic [PRIO_W-1:0] mask
);
  localparam int TOP = PRIO_W - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= RESET_VAL;
    end else if (wr_en) begin
      case (kind)
        ACC_RAW:     mask <= wr_data;
        ACC_NS_OPEN: mask <= {1'b1, wr_data[TOP:1]};
        default:     mask <= mask;
      endcase
    end
  end

  assert_reset_value_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> mask == RESET_VAL);
  assert_locked_write_dropped_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && kind == ACC_NS_LOCKED) |=> $stable(mask));
  assert_open_write_forces_top_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && kind == ACC_NS_OPEN) |=> (mask[TOP] && mask[TOP-1:0] == $past(wr_data[TOP:1])));
  assert_raw_write_exact_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && kind == ACC_RAW) |=> mask == $past(wr_data));
endmodule

// File: rtl/pmask_view.sv
module pmask_view
  import pmask_pkg::*;
#(
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  acc_kind_e         kind,
  input  logic [PRIO_W-1:0] mask,
  output logic [PRIO_W-1:0] rd_data
);
  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (kind)
        ACC_RAW:     rd_data = mask;
        ACC_NS_OPEN: rd_data = {mask[PRIO_W-2:0], 1'b0};
        default:     rd_data = '0;
      endcase
    end
  end

  assert_locked_read_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && kind == ACC_NS_LOCKED) |-> rd_data == '0);
  assert_idle_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> rd_data == '0);
endmodule

// File: rtl/pmask_gate.sv
module pmask_gate #(
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PRIO_W-1:0] mask,
  input  logic              pend_valid,
  input  logic [PRIO_W-1:0] pend_prio,
  output logic              irq_ok
);
  always_comb irq_ok = pend_valid && (pend_prio < mask);

  assert_lowest_never_passes_R7: assert property (@(posedge clk) disable iff (rst)
    irq_ok |-> (pend_valid && pend_prio != '1));
  assert_zero_mask_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |-> !irq_ok);
endmodule

// File: rtl/prio_mask_bank.sv
module prio_mask_bank
  import pmask_pkg::*;
#(
  parameter int PRIO_W = 8,
  parameter bit HAS_TOP_EL = 1'b1,
  parameter logic [PRIO_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_ns,
  input  logic              route_top,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [PRIO_W-1:0] wr_data,
  output logic [PRIO_W-1:0] rd_data,
  input  logic              pend_valid,
  input  logic [PRIO_W-1:0] pend_prio,
  output logic              irq_ok
);
  logic [PRIO_W-1:0] mask_q;
  acc_kind_e         kind;

  always_comb kind = classify(HAS_TOP_EL, acc_ns, route_top, mask_q[PRIO_W-1]);

  pmask_store #(.PRIO_W(PRIO_W), .RESET_VAL(RESET_VAL)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .kind(kind),
    .wr_data(wr_data), .mask(mask_q)
  );

  pmask_view #(.PRIO_W(PRIO_W)) u_view (
    .clk(clk), .rst(rst), .rd_en(rd_en), .kind(kind),
    .mask(mask_q), .rd_data(rd_data)
  );

  pmask_gate #(.PRIO_W(PRIO_W)) u_gate (
    .clk(clk), .rst(rst), .mask(mask_q), .pend_valid(pend_valid),
    .pend_prio(pend_prio), .irq_ok(irq_ok)
  );

  assert_secure_read_raw_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !acc_ns) |-> rd_data == mask_q);
  generate
    if (!HAS_TOP_EL) begin : g_no_top
      assert_never_translated_R9: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> rd_data == mask_q);
    end
  endgenerate
endmodule

// File: tb/tb_prio_mask_bank.sv
module tb_prio_mask_bank;
  localparam int W = 8;
  logic clk = 0, rst = 1;
  logic acc_ns = 0, route_top = 0, rd_en = 0, wr_en = 0, pend_valid = 0;
  logic [W-1:0] wr_data = '0, pend_prio = '0;
  logic [W-1:0] rd_data, rd_data2;
  logic irq_ok, irq_ok2;
  int errors = 0, checks = 0;
  logic [W-1:0] m1 = '0, m2 = '0;
  bit done = 0;

  always #4 clk = ~clk;

  prio_mask_bank #(.PRIO_W(W), .HAS_TOP_EL(1'b1)) dut (
    .clk, .rst, .acc_ns, .route_top, .rd_en, .wr_en, .wr_data,
    .rd_data(rd_data), .pend_valid, .pend_prio, .irq_ok(irq_ok));
  prio_mask_bank #(.PRIO_W(W), .HAS_TOP_EL(1'b0)) dut_noel (
    .clk, .rst, .acc_ns, .route_top, .rd_en, .wr_en, .wr_data,
    .rd_data(rd_data2), .pend_valid, .pend_prio, .irq_ok(irq_ok2));

  function automatic logic [W-1:0] exp_read(logic [W-1:0] m, logic x);
    if (!x) return m;
    if (m[W-1]) return {m[W-2:0], 1'b0};
    return '0;
  endfunction
  function automatic logic [W-1:0] exp_write(logic [W-1:0] m, logic x, logic [W-1:0] d);
    if (!x) return d;
    if (m[W-1]) return {1'b1, d[W-1:1]};
    return m;
  endfunction

  task automatic chk(string req, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive an access at the falling edge; reads are checked before the rising edge
  task automatic access(logic ns, logic rt, logic wr, logic [W-1:0] d, string req);
    logic x;
    @(negedge clk);
    acc_ns = ns; route_top = rt; rd_en = 1; wr_en = wr; wr_data = d;
    #2;
    x = ns & rt;
    chk(req, rd_data, exp_read(m1, x));
    chk("R9", rd_data2, m2);
    @(posedge clk);
    if (wr) begin
      m1 = exp_write(m1, x, d);
      m2 = d;
    end
    #1 wr_en = 0; rd_en = 0;
  endtask

  task automatic sec_write(logic [W-1:0] d);
    @(negedge clk);
    acc_ns = 0; wr_en = 1; wr_data = d;
    @(posedge clk); m1 = d; m2 = d;
    #1 wr_en = 0;
  endtask

  task automatic pend(logic v, logic [W-1:0] p, string req);
    @(negedge clk);
    pend_valid = v; pend_prio = p;
    #2;
    chk(req, {7'b0, irq_ok}, {7'b0, v && (p < m1)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    // R1 reset state
    access(0, 0, 0, 8'h00, "R1");
    pend(1, 8'h00, "R1");
    // R3 0xFF -> 0xFE
    sec_write(8'hFF);
    access(1, 1, 0, 8'h00, "R3");
    // R4 0x7F reads as zero; R7 secure higher priority passes, lower masked
    sec_write(8'h7F);
    access(1, 1, 0, 8'h00, "R4");
    pend(1, 8'h10, "R7");
    pend(1, 8'h90, "R7");
    // R5 locked write dropped
    access(1, 1, 1, 8'h22, "R5");
    access(0, 1, 0, 8'h00, "R5");
    chk("R5", m1, 8'h7F);
    // R6 accepted translated write
    sec_write(8'h80);
    access(1, 1, 1, 8'h40, "R6");
    access(0, 0, 0, 8'h00, "R6");
    chk("R6", m1, 8'hA0);
    access(1, 1, 0, 8'h00, "R3");
    // R2 routing clear: raw
    access(1, 0, 1, 8'h13, "R2");
    access(1, 0, 0, 8'h00, "R2");
    // R7 equal masked
    pend(1, 8'h13, "R7");
    pend(1, 8'h12, "R7");
    pend(0, 8'h00, "R7");
    // R8 simultaneous read sees old value
    access(0, 0, 1, 8'h55, "R8");
    access(0, 0, 0, 8'h00, "R8");
    @(negedge clk); #2 chk("R8", rd_data, 8'h00);
    // R9 routed non-secure write on instance without top level
    access(1, 1, 1, 8'h31, "R9");
    access(1, 1, 0, 8'h00, "R9");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] p;
      access(1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), "R2-R6 random");
      p = m1 + 8'($urandom_range(0, 4)) - 8'd2;
      pend(1'($urandom), p, "R7");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule